// File: doc/BRIEF.md
# Tagged Word Access Guard

This block sits between a stack-machine datapath and its memory and enforces the type rules carried by every stored word. Each word is a data field plus a small hardware type tag. For every request the guard decides, in the same cycle, whether the operation may proceed, and it presents the word as it should be written back: changed when the operation is allowed, and identical to the stored word and tag when it is refused.

Four operations are checked: an operand read, an overwrite with a fresh data value, a tag change, and an instruction fetch. Reading a word marked uninitialized is refused, although overwriting such a word is always allowed. In user mode a tag change may not create a code word, and it may not mark a word as a data descriptor while the word's most significant data bit is set. This stops user code from forging a descriptor that claims to point at resident memory. In privileged mode any tag change goes through. A fetched instruction word must carry the code tag. Every refusal leaves a fault code in a register for one cycle, together with a one-cycle strobe.

Top module: `tag_guard`

## Requirements
- R1: An operand read (opCode 0) of a word whose tag is not 6 is permitted, and the result equals the stored data and tag.
- R2: An operand read of a word with tag 6 (uninitialized) is refused, and faultCode is 1 in the cycle after the request.
- R3: An overwrite (opCode 1) is always permitted, including onto a tag-6 word. The result is newData with tag 0, and no fault is raised.
- R4: In user mode (privMode 0), a tag change (opCode 2) to tag 0, 2, 4, 6, 1 or 7, or to tag 5 when data bit 47 is 0, is permitted. The result keeps the stored data and carries the requested tag.
- R5: In user mode, a tag change to tag 5 on a word whose data bit 47 is 1 is refused, with faultCode 2.
- R6: In user mode, a tag change to tag 3 is refused, with faultCode 2.
- R7: In privileged mode (privMode 1), every tag change is permitted and no fault is raised.
- R8: An instruction fetch (opCode 3) is permitted only when the stored tag is 3. Any other tag is refused, with faultCode 3.
- R9: When a request is refused, the result data and tag equal the stored data and tag.
- R10: faultCode (0 none, 1 uninitialized read, 2 illegal tag change, 3 bad code tag) is registered from the previous cycle's request. faultStrobe is high for exactly that one cycle when the code is non-zero. Both are 0 after reset.
- R11: When reqValid is 0, permit is 0, the result equals the stored word, and faultCode is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| opCode | input | 2 | 0 read, 1 overwrite, 2 tag change, 3 fetch |
| privMode | input | 1 | 1 when the request comes from privileged code |
| inData | input | DATA_W | Data field of the stored word |
| inTag | input | 3 | Tag of the stored word |
| newData | input | DATA_W | Replacement data for an overwrite |
| newTag | input | 3 | Requested tag for a tag change |
| permit | output | 1 | The operation may proceed |
| outData | output | DATA_W | Data field of the resulting word |
| outTag | output | 3 | Tag of the resulting word |
| faultCode | output | 2 | Registered fault code of the previous request |
| faultStrobe | output | 1 | One-cycle pulse when faultCode is non-zero |

## Verification
The bench builds the guard with its default 48-bit data field, so the forging rule is exercised on the real top bit 47. Directed cases cover every tag under each operation in both modes, and the descriptor tag is applied with bit 47 both set and clear. A long pseudo-random stretch follows. It brings within reach back-to-back faults of different kinds, faults followed directly by idle cycles, and uninitialized words that are overwritten and then read.

// File: rtl/tag_guard_pkg.sv
package tag_guard_pkg;
  localparam int TAG_W = 3;

  localparam logic [TAG_W-1:0] TAG_PLAIN  = 3'd0;
  localparam logic [TAG_W-1:0] TAG_CODE   = 3'd3;
  localparam logic [TAG_W-1:0] TAG_DESC   = 3'd5;
  localparam logic [TAG_W-1:0] TAG_UNINIT = 3'd6;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RETAG = 2'd2,
    OP_FETCH = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_UNINIT = 2'd1,
    FLT_RETAG  = 2'd2,
    FLT_CODE   = 2'd3
  } fault_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   permit;
    logic   loadNew;
    logic   retag;
    fault_e fault;
  } ctrl_s;
endpackage

// File: rtl/tag_guard_ctrl.sv
module tag_guard_ctrl
  import tag_guard_pkg::*;
(
  input  logic             reqValid,
  input  op_e              op,
  input  logic             privMode,
  input  logic             wordMsb,
  input  logic [TAG_W-1:0] curTag,
  input  logic [TAG_W-1:0] reqTag,
  output ctrl_s            ctl
);
  localparam int NUM_TAGS = 1 << TAG_W;

  // even tags are freely usable data classes
  logic [NUM_TAGS-1:0] dataClass;
  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_class
    assign dataClass[g] = ((g % 2) == 0);
  end

  logic forgeDesc;
  logic makeCode;
  logic userRetagOk;

  always_comb begin
    forgeDesc   = (reqTag == TAG_DESC) && wordMsb;
    makeCode    = (reqTag == TAG_CODE);
    userRetagOk = dataClass[reqTag] || !(forgeDesc || makeCode);
  end

  always_comb begin
    ctl.permit  = 1'b0;
    ctl.loadNew = 1'b0;
    ctl.retag   = 1'b0;
    ctl.fault   = FLT_NONE;
    if (reqValid) begin
      unique case (op)
        OP_READ: begin
          if (curTag == TAG_UNINIT) ctl.fault = FLT_UNINIT;
          else                      ctl.permit = 1'b1;
        end
        OP_WRITE: begin
          ctl.permit  = 1'b1;
          ctl.loadNew = 1'b1;
        end
        OP_RETAG: begin
          if (privMode || userRetagOk) begin
            ctl.permit = 1'b1;
            ctl.retag  = 1'b1;
          end else begin
            ctl.fault = FLT_RETAG;
          end
        end
        OP_FETCH: begin
          if (curTag == TAG_CODE) ctl.permit = 1'b1;
          else                    ctl.fault = FLT_CODE;
        end
        default: ctl.fault = FLT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/tag_guard_dp.sv
module tag_guard_dp
  import tag_guard_pkg::*;
#(
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_s             ctl,
  input  logic [DATA_W-1:0] inData,
  input  logic [TAG_W-1:0]  inTag,
  input  logic [DATA_W-1:0] newData,
  input  logic [TAG_W-1:0]  newTag,
  output logic [DATA_W-1:0] outData,
  output logic [TAG_W-1:0]  outTag,
  output logic [1:0]        faultCode,
  output logic              faultStrobe
);
  always_comb begin
    outData = inData;
    outTag  = inTag;
    if (ctl.loadNew) begin
      outData = newData;
      outTag  = TAG_PLAIN;
    end else if (ctl.retag) begin
      outTag = newTag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      faultCode   <= 2'd0;
      faultStrobe <= 1'b0;
    end else begin
      faultCode   <= ctl.fault;
      faultStrobe <= (ctl.fault != FLT_NONE);
    end
  end
endmodule

// File: rtl/tag_guard.sv
module tag_guard
  import tag_guard_pkg::*;
#(
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [1:0]        opCode,
  input  logic              privMode,
  input  logic [DATA_W-1:0] inData,
  input  logic [2:0]        inTag,
  input  logic [DATA_W-1:0] newData,
  input  logic [2:0]        newTag,
  output logic              permit,
  output logic [DATA_W-1:0] outData,
  output logic [2:0]        outTag,
  output logic [1:0]        faultCode,
  output logic              faultStrobe
);
  ctrl_s ctl;

  tag_guard_ctrl u_ctrl (
    .reqValid (reqValid),
    .op       (op_e'(opCode)),
    .privMode (privMode),
    .wordMsb  (inData[DATA_W-1]),
    .curTag   (inTag),
    .reqTag   (newTag),
    .ctl      (ctl)
  );

  tag_guard_dp #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl         (ctl),
    .inData      (inData),
    .inTag       (inTag),
    .newData     (newData),
    .newTag      (newTag),
    .outData     (outData),
    .outTag      (outTag),
    .faultCode   (faultCode),
    .faultStrobe (faultStrobe)
  );

  assign permit = ctl.permit;
endmodule

// File: rtl/tag_guard_chk.sv
module tag_guard_chk #(
  parameter int DATA_W = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic [1:0]        opCode,
  input logic              privMode,
  input logic [DATA_W-1:0] inData,
  input logic [2:0]        inTag,
  input logic [2:0]        newTag,
  input logic              permit,
  input logic [DATA_W-1:0] outData,
  input logic [2:0]        outTag,
  input logic [1:0]        faultCode,
  input logic              faultStrobe
);
  p_uninit_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && opCode == 2'd0 && inTag == 3'd6) |=> (faultCode == 2'd1 && faultStrobe));

  p_forge_desc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && opCode == 2'd2 && !privMode && newTag == 3'd5 && inData[DATA_W-1]) |-> !permit);

  p_no_code_retag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && opCode == 2'd2 && !privMode && newTag == 3'd3) |=> (faultCode == 2'd2));

  p_priv_retag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && opCode == 2'd2 && privMode) |-> permit);

  p_fetch_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && opCode == 2'd3 && inTag != 3'd3) |=> (faultCode == 2'd3));

  p_refuse_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !permit |-> (outData == inData && outTag == inTag));

  p_strobe_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
    faultStrobe == (faultCode != 2'd0));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !faultStrobe);
endmodule

bind tag_guard tag_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reqValid    (reqValid),
  .opCode      (opCode),
  .privMode    (privMode),
  .inData      (inData),
  .inTag       (inTag),
  .newTag      (newTag),
  .permit      (permit),
  .outData     (outData),
  .outTag      (outTag),
  .faultCode   (faultCode),
  .faultStrobe (faultStrobe)
);

// File: tb/tag_guard_tb.sv
module tag_guard_tb;
  localparam int DW = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    opCode = 2'd0;
  logic          privMode = 1'b0;
  logic [DW-1:0] inData = '0;
  logic [2:0]    inTag = 3'd0;
  logic [DW-1:0] newData = '0;
  logic [2:0]    newTag = 3'd0;
  logic          permit;
  logic [DW-1:0] outData;
  logic [2:0]    outTag;
  logic [1:0]    faultCode;
  logic          faultStrobe;

  int checks = 0;
  int fails  = 0;
  int prevFault = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tag_guard #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .opCode(opCode),
    .privMode(privMode), .inData(inData), .inTag(inTag), .newData(newData),
    .newTag(newTag), .permit(permit), .outData(outData), .outTag(outTag),
    .faultCode(faultCode), .faultStrobe(faultStrobe)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string reqOf(input bit v, input int op, input bit pv,
                                  input int t, input int nt, input bit msb);
    if (!v) return "R11";
    case (op)
      0: return (t == 6) ? "R2" : "R1";
      1: return "R3";
      2: if (pv) return "R7";
         else if (nt == 3) return "R6";
         else if (nt == 5 && msb) return "R5";
         else return "R4";
      default: return "R8";
    endcase
  endfunction

  // one request: drive after falling edge, check before rising edge
  task automatic step(input bit v, input int op, input bit pv,
                      input logic [DW-1:0] d, input int t,
                      input logic [DW-1:0] nd, input int nt);
    bit expPermit;
    logic [DW-1:0] expData;
    int expTag;
    int expFault;
    string rq;
    @(negedge clk);
    reqValid = v; opCode = op[1:0]; privMode = pv; inData = d;
    inTag = t[2:0]; newData = nd; newTag = nt[2:0];
    expPermit = 0; expData = d; expTag = t; expFault = 0;
    if (v) begin
      if (op == 0) begin
        if (t == 6) expFault = 1; else expPermit = 1;
      end else if (op == 1) begin
        expPermit = 1; expData = nd; expTag = 0;
      end else if (op == 2) begin
        if (!pv && (nt == 3 || (nt == 5 && d[DW-1]))) expFault = 2;
        else begin expPermit = 1; expTag = nt; end
      end else begin
        if (t == 3) expPermit = 1; else expFault = 3;
      end
    end
    rq = reqOf(v, op, pv, t, nt, d[DW-1]);
    #5;
    check({rq, " permit"}, 64'(permit), 64'(expPermit));
    check({(expPermit ? rq : "R9"), " data"}, 64'(outData), 64'(expData));
    check({(expPermit ? rq : "R9"), " tag"}, 64'(outTag), 64'(expTag));
    check("R10 code", 64'(faultCode), 64'(prevFault));
    check("R10 strobe", 64'(faultStrobe), 64'(prevFault != 0));
    prevFault = expFault;
  endtask

  initial begin
    logic [DW-1:0] hi;
    logic [DW-1:0] lo;
    hi = {1'b1, {(DW-1){1'b0}}} | 48'h1234;
    lo = 48'h0000_5678_9abc;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R10 reset code", 64'(faultCode), 64'd0);
    check("R10 reset strobe", 64'(faultStrobe), 64'd0);
    rst_n = 1'b1;
    // R1 / R2: reads over all tags
    for (int t = 0; t < 8; t++) step(1, 0, 0, lo ^ DW'(t), t, '0, 0);
    // R3: overwrite onto every tag, including uninitialized
    for (int t = 0; t < 8; t++) step(1, 1, 0, hi, t, lo + DW'(t), 5);
    // R4, R5, R6: user tag changes with bit 47 clear and set
    for (int nt = 0; nt < 8; nt++) step(1, 2, 0, lo, 0, '0, nt);
    for (int nt = 0; nt < 8; nt++) step(1, 2, 0, hi, 2, '0, nt);
    // R7: privileged tag changes
    for (int nt = 0; nt < 8; nt++) step(1, 2, 1, hi, 0, '0, nt);
    // R8: fetch over all tags
    for (int t = 0; t < 8; t++) step(1, 3, 0, lo, t, '0, 0);
    // R10: back-to-back faults of different kinds then idle
    step(1, 0, 0, lo, 6, '0, 0);
    step(1, 2, 0, hi, 0, '0, 5);
    step(1, 3, 0, lo, 1, '0, 0);
    step(0, 3, 0, lo, 1, '0, 0);
    // R11: idle with a faulting pattern on the inputs
    step(0, 0, 0, lo, 6, '0, 0);
    step(1, 0, 0, lo, 0, '0, 0);
    // random stretch
    for (int i = 0; i < 2000; i++) begin
      logic [DW-1:0] rd;
      logic [DW-1:0] rn;
      rd = {$urandom, $urandom};
      rn = {$urandom, $urandom};
      step(($urandom % 8) != 0, int'($urandom % 4), $urandom % 2, rd,
           int'($urandom % 8), rn, int'($urandom % 8));
    end
    step(0, 0, 0, lo, 0, '0, 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule